// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns one column access request into the full list of column addresses for a READ or WRITE burst. A one-cycle start pulse supplies the starting column, a burst-length code, an ordering choice and the access direction. On each following clock the block presents one column address, with a valid strobe and a beat index. A last flag marks the final beat.

Every beat of a burst stays inside the aligned group of columns that holds the starting column. The size of that group equals the burst length. The starting column's low bits give the entry point within the group. The walk through the group is either sequential, wrapping at the group edge, or interleaved, where the beat index is XORed into the low bits. A single-location write option cuts write bursts to one beat and leaves reads at the programmed length.

Command sequencing, CAS latency and data movement are handled by the surrounding controller. This block only produces the address stream that the controller consumes.

Top module: `sdram_burst_colgen`

## Requirements
- R1: The burst-length code `bl_code_i` selects 1, 2, 4 or 8 beats for codes 0, 1, 2, 3. `valid_o` is high for exactly that many consecutive cycles, and `beat_o` counts 0, 1, 2 and so on.
- R2: The first beat appears in the cycle after the clock edge that samples `start_i`. It carries beat index 0 and exactly the starting column `col_start_i`.
- R3: With `interleave_i` = 0 (sequential), beat k has low bits equal to (start low bits + k) modulo L, where L is the burst length and the low field is log2(L) bits wide.
- R4: With `interleave_i` = 1 (interleaved), beat k has low bits equal to the start low bits XOR k.
- R5: Column bits from log2(L) up to bit 8 are identical on every beat of a burst. A wrap at the group edge never carries into them.
- R6: When `single_wr_i` = 1 and `is_write_i` = 1, the burst has exactly one beat, which has `last_o` high. A read with `single_wr_i` = 1, and a write with `single_wr_i` = 0, keep the programmed length.
- R7: `last_o` is high only on the final beat of a burst. Unless a new start arrives, `valid_o` is low in the cycle after that beat.
- R8: A start pulse that arrives while a burst is active abandons the rest of the old burst. Beat 0 of the new burst appears in the next cycle.
- R9: While reset is applied and after reset is released, `valid_o` and `last_o` are low until the first start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle pulse that launches a burst |
| is_write_i | input | 1 | 1 for a write burst, 0 for a read burst |
| col_start_i | input | 9 | Starting column address |
| bl_code_i | input | 2 | Burst length code: 0→1, 1→2, 2→4, 3→8 |
| interleave_i | input | 1 | 0 for sequential order, 1 for interleaved order |
| single_wr_i | input | 1 | 1 forces write bursts to a single beat |
| col_o | output | 9 | Column address of the current beat |
| valid_o | output | 1 | High while a beat is presented |
| last_o | output | 1 | High on the final beat of a burst |
| beat_o | output | 3 | Index of the current beat within the burst |

## Verification
The hardest case to reach from the ports is a start pulse that lands in the middle of a running burst. The new configuration must win on the very next beat, and the stale count must not finish the old burst. The bench reaches this case by launching long bursts and issuing a second start at chosen beat offsets, including the final beat. It then checks that beat 0 of the new burst follows at once. The group wrap is covered by sweeping every starting column under every length and both orders, so every entry offset and every upper-bit pattern is crossed.

// File: rtl/burst_colgen_pkg.sv
package burst_colgen_pkg;

  // Walk order through the aligned column group
  typedef enum logic {
    ORDER_LINEAR = 1'b0,
    ORDER_XOR    = 1'b1
  } burst_order_e;

endpackage

// File: rtl/burst_cfg_reg.sv
module burst_cfg_reg
  import burst_colgen_pkg::*;
#(
  parameter int COL_W  = 9,
  parameter int MAX_LG = 3,
  parameter int LG_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic [COL_W-1:0]   col_i,
  input  logic [LG_W-1:0]    code_i,
  input  logic               is_write_i,
  input  logic               single_wr_i,
  input  logic               interleave_i,
  output logic [COL_W-1:0]   col_q,
  output logic [LG_W-1:0]    lg_q,
  output burst_order_e       order_q
);

  localparam logic [LG_W-1:0] LG_CAP = LG_W'(MAX_LG);

  // Effective log2 length after the single-write override and capping
  function automatic logic [LG_W-1:0] pick_lg(
    input logic [LG_W-1:0] code,
    input logic            wr,
    input logic            single
  );
    if (wr && single) return '0;
    if (code > LG_CAP) return LG_CAP;
    return code;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q   <= '0;
      lg_q    <= '0;
      order_q <= ORDER_LINEAR;
    end else if (load_i) begin
      col_q   <= col_i;
      lg_q    <= pick_lg(code_i, is_write_i, single_wr_i);
      order_q <= interleave_i ? ORDER_XOR : ORDER_LINEAR;
    end
  end

endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int BEAT_W = 3,
  parameter int LG_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [LG_W-1:0]   lg_i,
  output logic [BEAT_W-1:0] beat_q,
  output logic              active_q,
  output logic              final_o
);

  // Highest beat index for a length of 2**lg
  function automatic logic [BEAT_W-1:0] top_beat(input logic [LG_W-1:0] lg);
    logic [BEAT_W:0] span;
    span = (BEAT_W+1)'(1) << lg;
    return span[BEAT_W-1:0] - 1'b1;
  endfunction

  logic [BEAT_W-1:0] beat_top;
  assign beat_top = top_beat(lg_i);
  assign final_o  = active_q && (beat_q == beat_top);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_q   <= '0;
      active_q <= 1'b0;
    end else if (start_i) begin
      beat_q   <= '0;
      active_q <= 1'b1;
    end else if (active_q) begin
      if (final_o) begin
        active_q <= 1'b0;
        beat_q   <= '0;
      end else begin
        beat_q <= beat_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/burst_col_map.sv
module burst_col_map
  import burst_colgen_pkg::*;
#(
  parameter int COL_W  = 9,
  parameter int BEAT_W = 3,
  parameter int LG_W   = 2
) (
  input  logic [COL_W-1:0]  base_i,
  input  logic [LG_W-1:0]   lg_i,
  input  burst_order_e      order_i,
  input  logic [BEAT_W-1:0] beat_i,
  output logic [COL_W-1:0]  col_o
);

  function automatic logic [COL_W-1:0] group_mask(input logic [LG_W-1:0] lg);
    return (COL_W'(1) << lg) - 1'b1;
  endfunction

  function automatic logic [COL_W-1:0] linear_low(
    input logic [COL_W-1:0] base, input logic [COL_W-1:0] mask, input logic [BEAT_W-1:0] beat
  );
    return ((base & mask) + COL_W'(beat)) & mask;
  endfunction

  function automatic logic [COL_W-1:0] xor_low(
    input logic [COL_W-1:0] base, input logic [COL_W-1:0] mask, input logic [BEAT_W-1:0] beat
  );
    return ((base & mask) ^ COL_W'(beat)) & mask;
  endfunction

  logic [COL_W-1:0] mask, low_lin, low_xor, low_sel;

  assign mask    = group_mask(lg_i);
  assign low_lin = linear_low(base_i, mask, beat_i);
  assign low_xor = xor_low(base_i, mask, beat_i);
  assign low_sel = (order_i == ORDER_XOR) ? low_xor : low_lin;
  assign col_o   = (base_i & ~mask) | low_sel;

endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
  import burst_colgen_pkg::*;
#(
  parameter int COL_W  = 9,
  parameter int MAX_LG = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              is_write_i,
  input  logic [COL_W-1:0]  col_start_i,
  input  logic [1:0]        bl_code_i,
  input  logic              interleave_i,
  input  logic              single_wr_i,
  output logic [COL_W-1:0]  col_o,
  output logic              valid_o,
  output logic              last_o,
  output logic [MAX_LG-1:0] beat_o
);

  localparam int BEAT_W = MAX_LG;
  localparam int LG_W   = 2;

  logic [COL_W-1:0]  base_q;
  logic [LG_W-1:0]   lg_q;
  burst_order_e      order_q;
  logic [BEAT_W-1:0] beat_q;
  logic              active_q;
  logic              final_beat;

  // Named events for the checker
  logic burst_launch, burst_abort, burst_done;
  assign burst_launch = start_i;
  assign burst_abort  = start_i && active_q && !final_beat;
  assign burst_done   = final_beat && !start_i;

  burst_cfg_reg #(.COL_W(COL_W), .MAX_LG(MAX_LG), .LG_W(LG_W)) u_cfg (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (burst_launch),
    .col_i       (col_start_i),
    .code_i      (bl_code_i),
    .is_write_i  (is_write_i),
    .single_wr_i (single_wr_i),
    .interleave_i(interleave_i),
    .col_q       (base_q),
    .lg_q        (lg_q),
    .order_q     (order_q)
  );

  burst_beat_ctr #(.BEAT_W(BEAT_W), .LG_W(LG_W)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (burst_launch),
    .lg_i    (lg_q),
    .beat_q  (beat_q),
    .active_q(active_q),
    .final_o (final_beat)
  );

  burst_col_map #(.COL_W(COL_W), .BEAT_W(BEAT_W), .LG_W(LG_W)) u_map (
    .base_i (base_q),
    .lg_i   (lg_q),
    .order_i(order_q),
    .beat_i (beat_q),
    .col_o  (col_o)
  );

  assign valid_o = active_q;
  assign last_o  = final_beat;
  assign beat_o  = beat_q;

endmodule

// File: rtl/sdram_burst_colgen_chk.sv
module sdram_burst_colgen_chk #(
  parameter int COL_W  = 9,
  parameter int BEAT_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              is_write_i,
  input logic              single_wr_i,
  input logic [COL_W-1:0]  col_start_i,
  input logic [COL_W-1:0]  col_o,
  input logic              valid_o,
  input logic              last_o,
  input logic [BEAT_W-1:0] beat_o,
  input logic              burst_abort,
  input logic              burst_done
);

  AST_START_FIRST_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (valid_o && beat_o == '0 && col_o == $past(col_start_i))); // R2

  AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !last_o && !start_i) |=> (valid_o && beat_o == BEAT_W'($past(beat_o) + 1'b1))); // R1

  AST_UPPER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !last_o && !start_i) |=> $stable(col_o[COL_W-1:BEAT_W])); // R5

  AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && is_write_i && single_wr_i) |=> last_o); // R6

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |=> !valid_o); // R7

  AST_LAST_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> valid_o); // R7

  AST_ABORT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    burst_abort |=> (valid_o && beat_o == '0)); // R8

  always_comb begin
    if (!rst_n) AST_RESET_QUIET: assert (!valid_o && !last_o); // R9
  end

endmodule

bind sdram_burst_colgen sdram_burst_colgen_chk #(.COL_W(COL_W), .BEAT_W(MAX_LG)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .is_write_i (is_write_i),
  .single_wr_i(single_wr_i),
  .col_start_i(col_start_i),
  .col_o      (col_o),
  .valid_o    (valid_o),
  .last_o     (last_o),
  .beat_o     (beat_o),
  .burst_abort(burst_abort),
  .burst_done (burst_done)
);

// File: tb/sdram_burst_colgen_test.sv
`timescale 1ns/1ps
module sdram_burst_colgen_test;

  localparam real HALF = 2.0;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic       is_write_i = 1'b0;
  logic [8:0] col_start_i = '0;
  logic [1:0] bl_code_i = '0;
  logic       interleave_i = 1'b0;
  logic       single_wr_i = 1'b0;
  logic [8:0] col_o;
  logic       valid_o, last_o;
  logic [2:0] beat_o;

  int checks = 0;
  int errors = 0;

  always #(HALF) clk = ~clk;

  sdram_burst_colgen uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .is_write_i(is_write_i),
    .col_start_i(col_start_i), .bl_code_i(bl_code_i), .interleave_i(interleave_i),
    .single_wr_i(single_wr_i), .col_o(col_o), .valid_o(valid_o), .last_o(last_o),
    .beat_o(beat_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int expect_col(input int col, input int len, input bit intl, input int k);
    int grp, off, pos;
    grp = (col / len) * len;
    off = col % len;
    pos = intl ? (off ^ k) : ((off + k) % len);
    return grp + pos;
  endfunction

  // Drive a start at a falling edge; outputs of beat 0 are read one cycle later
  task automatic launch(input int col, input int code, input bit intl, input bit wr, input bit single);
    @(negedge clk);
    col_start_i = 9'(col); bl_code_i = 2'(code); interleave_i = intl;
    is_write_i = wr; single_wr_i = single; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic follow(input int col, input int len, input bit intl, input string tag);
    for (int k = 0; k < len; k++) begin
      chk(k == 0 ? "R2" : tag,
          {valid_o, last_o, beat_o, col_o},
          {1'b1, (k == len - 1), 3'(k), 9'(expect_col(col, len, intl, k))});
      chk("R5", int'(col_o) / len, col / len);
      chk("R7", int'(last_o), (k == len - 1) ? 1 : 0);
      @(negedge clk);
    end
    chk("R1", int'(valid_o), 0);
  endtask

  initial begin
    #(HALF * 2 * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9", {valid_o, last_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9", {valid_o, last_o}, 0);

    // R3 R4 R1: every start column, every length, both orders, reads
    for (int code = 0; code < 4; code++)
      for (int intl = 0; intl < 2; intl++)
        for (int col = 0; col < 512; col++) begin
          launch(col, code, 1'(intl), 1'b0, 1'b0);
          follow(col, 1 << code, 1'(intl), intl ? "R4" : "R3");
        end

    // R6: single-location writes vs reads and normal writes
    for (int col = 0; col < 512; col += 37)
      for (int code = 0; code < 4; code++) begin
        launch(col, code, col[0], 1'b1, 1'b1);
        chk("R6", {valid_o, last_o, col_o}, {1'b1, 1'b1, 9'(col)});
        @(negedge clk);
        chk("R6", int'(valid_o), 0);
        launch(col, code, col[0], 1'b0, 1'b1);
        follow(col, 1 << code, col[0], "R6");
        launch(col, code, col[0], 1'b1, 1'b0);
        follow(col, 1 << code, col[0], "R6");
      end

    // R8: restart at each beat offset of a length-8 burst
    for (int cut = 0; cut < 8; cut++) begin
      launch(9'h0F5, 3, 1'b1, 1'b0, 1'b0);
      for (int k = 0; k < cut; k++) @(negedge clk);
      chk("R8", int'(beat_o), cut);
      col_start_i = 9'h16A; bl_code_i = 2'd2; interleave_i = 1'b0; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      follow(9'h16A, 4, 1'b0, "R8");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule